// File: doc/BRIEF.md
# Serial EEPROM Slave on an I2C Bus

This block behaves as a byte-addressed serial memory attached to a two-wire I2C bus. It runs entirely in the system clock domain. SCL and SDA are brought in through two-stage synchronisers and examined for edges, START conditions and STOP conditions. SDA is driven only through an open-drain pull-down enable, `sdaOe`. The board is expected to combine that enable with the master's drive into a wired-AND line, and that line comes back on `sdaIn`.

A transfer opens with a START, followed by a control byte. The control byte names the device type and selects one of up to eight devices through three strap inputs. If the byte matches, the slave acknowledges it. In a write, two address bytes follow, high byte first. These load an internal pointer, and any further bytes are stored at the pointer while it advances. In a read, the slave returns the byte at the pointer and advances it, and it keeps sending for as long as the master acknowledges. A random read is built from a write that only sets the address, then a repeated START and a read control byte.

The pointer width is the parameter `AW`. Its default of 11 gives a 2048-byte array. Setting `AW = 13` gives the full 8192-byte device, which keeps 13 of the 16 address bits.

Top module: `i2cee_slave`

## Requirements
- R1: During reset and right after it, `sdaOe` is 0 and the slave waits for a START.
- R2: The control byte is sent MSB first. Bits 7:4 must equal the type code 1010. Bits 3:1 carry the device select, with bit 3 compared to `chipSel[2]` and bit 1 compared to `chipSel[0]`. Bit 0 selects the direction: 1 means read and 0 means write.
- R3: If a control byte has the wrong type code or the wrong select bits, the slave does not acknowledge it. It then leaves SDA released and ignores every following byte until the next START, so a write sent in this state changes no memory location.
- R4: For every byte it accepts (a matching control byte, both address bytes and each write data byte), the slave pulls SDA low for the whole of the ninth SCL clock.
- R5: After a write control byte, the next byte is the high address byte and the one after it is the low byte. Only the low `AW` bits of the resulting 16-bit value are kept, and bits 15 down to `AW` have no effect.
- R6: Each data byte that follows the two address bytes is stored at the pointer, and the pointer then increments by one.
- R7: After a read control byte, the slave sends the byte at the pointer, MSB first, and increments the pointer. It sends the next byte if the master drives SDA low on the ninth clock. If the master leaves SDA high, the slave releases SDA until the next START.
- R8: The pointer wraps from 2^AW-1 to 0, on both writes and reads, and never moves past the device's own range.
- R9: Outside START and STOP, the slave changes `sdaOe` only while SCL is low.
- R10: A STOP at any point returns the slave to idle with SDA released, and a repeated START is accepted at any time. A transfer cut short before the low address byte leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Resolved bus data line level |
| chipSel | input | 3 | Strap value matched against control byte bits 3:1 |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The bench aims at the following corner cases:
- **High address bits.** An address with garbage in its upper bits must land at the same location as the clean address. A design that kept those bits would read back another byte.
- **Pointer wrap.** Writes and sequential reads run across the top address. A design that did not wrap would write past the end or return the wrong byte after the boundary.
- **Rejected control bytes.** A wrong select value and a wrong type code are each followed by a full write. A design that answered them, or stored the data anyway, would show an acknowledge or a corrupted byte on the next read.
- **End of a read.** A not-acknowledged read is followed by extra clocks, and a STOP arrives in the middle of the address bytes. A design that kept driving after the NACK would pull the line low, and one that half-loaded the pointer would return the wrong byte on the next current-address read.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } ctlState_e;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDRH,
    K_ADDRL,
    K_WDATA
  } byteKind_e;

  typedef struct packed {
    logic shiftIn;
    logic ldAddrHi;
    logic ldPtr;
    logic wrMem;
    logic ldTx;
    logic shiftTx;
    logic incPtr;
  } dpStrobe_t;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
  localparam int         BYTE_BITS = 8;

endpackage

// File: rtl/i2cee_busSync.sv
module i2cee_busSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclChain;
  logic [TOP:0] sdaChain;
  logic         sclPrev;
  logic         sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= scl;
          sdaChain <= sdaIn;
        end
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[TOP-1:0], scl};
          sdaChain <= {sdaChain[TOP-1:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclChain[TOP];
      sdaPrev <= sdaChain[TOP];
    end
  end

  assign sclLvl   = sclChain[TOP];
  assign sdaLvl   = sdaChain[TOP];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2cee_datapath.sv
module i2cee_datapath
  import i2cee_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic                  sdaLvl,
  output logic [BYTE_BITS-1:0]  rxByte,
  output logic                  txBit
);

  localparam int DEPTH  = 1 << AW;
  localparam int HI_W   = AW - BYTE_BITS;

  logic [BYTE_BITS-1:0] rxShift;
  logic [BYTE_BITS-1:0] txShift;
  logic [HI_W-1:0]      addrHi;
  logic [AW-1:0]        ptr;
  logic [BYTE_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.shiftIn) begin
      rxShift <= {rxShift[BYTE_BITS-2:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi <= '0;
    end else if (strb.ldAddrHi) begin
      addrHi <= rxShift[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ldPtr) begin
      ptr <= {addrHi, rxShift};
    end else if (strb.incPtr) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrMem) begin
      mem[ptr] <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strb.ldTx) begin
      txShift <= mem[ptr];
    end else if (strb.shiftTx) begin
      txShift <= {txShift[BYTE_BITS-2:0], 1'b1};
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[BYTE_BITS-1];

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && !strb.ldPtr) |=> (ptr == AW'($past(ptr) + 1'b1))); // R8

  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ldPtr, strb.wrMem, strb.ldTx, strb.ldAddrHi})); // R5

endmodule

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclLvl,
  input  logic                 sclRise,
  input  logic                 sclFall,
  input  logic                 sdaLvl,
  input  logic                 startDet,
  input  logic                 stopDet,
  input  logic [2:0]           chipSel,
  input  logic [BYTE_BITS-1:0] rxByte,
  input  logic                 txBit,
  output dpStrobe_t            strb,
  output logic                 sdaOe
);

  ctlState_e state, stateN;
  byteKind_e kind, kindN;
  logic [3:0] bitCnt, bitCntN;
  logic       rdMode, rdModeN;
  logic       ackDrive, ackN;
  logic       txMode, txModeN;
  logic       mAck, mAckN;
  logic       ctrlHit;
  logic       byteDone;

  assign ctrlHit  = (rxByte[7:4] == TYPE_CODE) && (rxByte[3:1] == chipSel);
  assign byteDone = sclFall && (bitCnt == 4'd8);

  always_comb begin
    stateN  = state;
    kindN   = kind;
    bitCntN = bitCnt;
    rdModeN = rdMode;
    ackN    = ackDrive;
    txModeN = txMode;
    mAckN   = mAck;
    strb    = '0;
    if (startDet) begin
      stateN  = ST_RX;
      kindN   = K_CTRL;
      bitCntN = '0;
      ackN    = 1'b0;
      txModeN = 1'b0;
    end else if (stopDet) begin
      stateN  = ST_IDLE;
      ackN    = 1'b0;
      txModeN = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            bitCntN      = bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCntN = '0;
            if (kind != K_CTRL || ctrlHit) begin
              stateN = ST_RXACK;
              ackN   = 1'b1;
              if (kind == K_CTRL) rdModeN = rxByte[0];
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            ackN = 1'b0;
            unique case (kind)
              K_CTRL: begin
                if (rdMode) begin
                  stateN      = ST_TX;
                  strb.ldTx   = 1'b1;
                  strb.incPtr = 1'b1;
                  txModeN     = 1'b1;
                end else begin
                  stateN = ST_RX;
                  kindN  = K_ADDRH;
                end
              end
              K_ADDRH: begin
                strb.ldAddrHi = 1'b1;
                stateN        = ST_RX;
                kindN         = K_ADDRL;
              end
              K_ADDRL: begin
                strb.ldPtr = 1'b1;
                stateN     = ST_RX;
                kindN      = K_WDATA;
              end
              default: begin
                strb.wrMem  = 1'b1;
                strb.incPtr = 1'b1;
                stateN      = ST_RX;
              end
            endcase
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCntN = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              bitCntN = '0;
              txModeN = 1'b0;
              stateN  = ST_TXACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            mAckN = ~sdaLvl;
          end else if (sclFall) begin
            if (mAck) begin
              stateN      = ST_TX;
              strb.ldTx   = 1'b1;
              strb.incPtr = 1'b1;
              txModeN     = 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= K_CTRL;
      bitCnt   <= '0;
      rdMode   <= 1'b0;
      ackDrive <= 1'b0;
      txMode   <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state    <= stateN;
      kind     <= kindN;
      bitCnt   <= bitCntN;
      rdMode   <= rdModeN;
      ackDrive <= ackN;
      txMode   <= txModeN;
      mAck     <= mAckN;
    end
  end

  assign sdaOe = ackDrive | (txMode & ~txBit);

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet || stopDet)) |-> !$past(sclLvl)); // R9

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && kind == K_CTRL && byteDone && !startDet && !stopDet &&
     (rxByte[7:4] != 4'b1010 || rxByte[3:1] != chipSel))
    |=> (state == ST_IDLE && !sdaOe)); // R3

  AST_ACK_TX_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackDrive, txMode})); // R4

  AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMem |-> (ackDrive && sclFall)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R10

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int AW          = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  output logic       sdaOe
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_BITS-1:0] rxByte;
  logic txBit;
  dpStrobe_t strb;

  i2cee_busSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .scl      (scl),
    .sdaIn    (sdaIn),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  i2cee_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclLvl   (sclLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .sdaLvl   (sdaLvl),
    .startDet (startDet),
    .stopDet  (stopDet),
    .chipSel  (chipSel),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .strb     (strb),
    .sdaOe    (sdaOe)
  );

  i2cee_datapath #(.AW(AW)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sdaLvl (sdaLvl),
    .rxByte (rxByte),
    .txBit  (txBit)
  );

endmodule

// File: tb/i2cee_slave_test.sv
module i2cee_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 11;
  localparam int DEPTH      = 1 << AW;
  localparam int Q          = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       mSda = 1'b1;
  logic [2:0] chipSel = STRAP;
  logic       sdaOe;
  logic       sdaBus;

  assign sdaBus = mSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cee_slave #(.AW(AW)) uut (
    .clk     (clk),
    .rstN    (rstN),
    .scl     (sclLine),
    .sdaIn   (sdaBus),
    .chipSel (chipSel),
    .sdaOe   (sdaOe)
  );

  int    vectors = 0;
  int    miscompares = 0;
  logic  expOe = 1'b0;
  string curReq = "R1";
  int    highCnt = 0;
  bit    monOn = 1'b0;
  logic [7:0] refMem [DEPTH];
  int    refPtr = 0;

  // per-clock comparison of the pull-down against the reference expectation (R9 scope)
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (sclLine) highCnt++; else highCnt = 0;
    if (monOn && sclLine && highCnt >= 2) begin
      vectors++;
      if (sdaOe !== expOe) begin
        miscompares++;
        $display("FAIL %s/R9 sdaOe actual=%b expected=%b t=%0t", curReq, sdaOe, expOe, $time);
      end
    end
  end

  task automatic waitQ(input int n);
    repeat (n*Q) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic slot(input logic d, input logic e, output logic seen);
    mSda = d; expOe = e;
    waitQ(1); sclLine = 1'b1;
    waitQ(1); seen = sdaBus;
    waitQ(1); sclLine = 1'b0;
    waitQ(1);
  endtask

  task automatic startCond();
    mSda = 1'b1; expOe = 1'b0;
    waitQ(1); sclLine = 1'b1;
    waitQ(1); mSda = 1'b0;
    waitQ(1); sclLine = 1'b0;
    waitQ(1);
  endtask

  task automatic stopCond();
    mSda = 1'b0; expOe = 1'b0;
    waitQ(1); sclLine = 1'b1;
    waitQ(1); mSda = 1'b1;
    waitQ(1);
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] sel, input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  task automatic sendByte(input logic [7:0] b, input logic ack, input string req);
    logic s;
    curReq = req;
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, s);
    slot(1'b1, ack, s);
    check(s === !ack, req, "ack line", int'(s), int'(!ack));
  endtask

  task automatic readByte(input logic [7:0] exp, input logic mAckIn, input string req);
    logic [7:0] got;
    logic s;
    curReq = req;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, ~exp[i], s);
      got[i] = s;
    end
    slot(!mAckIn, 1'b0, s);
    check(got === exp, req, "read byte", int'(got), int'(exp));
  endtask

  task automatic setAddr(input logic [15:0] a);
    startCond();
    sendByte(ctl(STRAP, 1'b0), 1'b1, "R2");
    sendByte(a[15:8], 1'b1, "R4");
    sendByte(a[7:0], 1'b1, "R5");
    refPtr = int'(a) % DEPTH;
  endtask

  task automatic writeSeq(input logic [15:0] a, input int n, input logic [31:0] pk);
    logic [7:0] d;
    setAddr(a);
    for (int k = 0; k < n; k++) begin
      d = pk[31-8*k -: 8];
      sendByte(d, 1'b1, "R6");
      refMem[refPtr] = d;
      refPtr = (refPtr + 1) % DEPTH;
    end
    stopCond();
  endtask

  task automatic readRun(input int n, input string req);
    startCond();
    sendByte(ctl(STRAP, 1'b1), 1'b1, "R2");
    for (int k = 0; k < n; k++) begin
      readByte(refMem[refPtr], k != n-1, req);
      refPtr = (refPtr + 1) % DEPTH;
    end
  endtask

  task automatic finishRun();
    monOn = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic s;
    // R1: reset state
    waitQ(2);
    check(sdaOe === 1'b0, "R1", "sdaOe in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    waitQ(2);
    check(sdaOe === 1'b0, "R1", "sdaOe after reset", int'(sdaOe), 0);
    monOn = 1'b1;

    // R5: upper address bits ignored (0xF923 aliases 0x123)
    writeSeq(16'hF923, 1, 32'h5A00_0000);
    setAddr(16'h0123);
    readRun(1, "R5");
    stopCond();

    // R8: write across the top of the array, then read across it
    writeSeq(16'h07FE, 3, 32'hA1B2_C300);
    setAddr(16'h07FE);
    readRun(3, "R8");
    stopCond();
    setAddr(16'h0000);
    readRun(1, "R8");
    stopCond();

    // R6/R7: sequential write, then current-address read continues the pointer
    writeSeq(16'h0040, 4, 32'h0102_0304);
    setAddr(16'h0040);
    readRun(2, "R6");
    stopCond();
    readRun(2, "R7");
    stopCond();

    // R3: wrong select value, full write attempt must be ignored
    startCond();
    sendByte({4'b1010, 3'b001, 1'b0}, 1'b0, "R3");
    sendByte(8'h01, 1'b0, "R3");
    sendByte(8'h23, 1'b0, "R3");
    sendByte(8'hEE, 1'b0, "R3");
    stopCond();
    setAddr(16'h0123);
    readRun(1, "R3");
    stopCond();

    // R3: wrong select on a read, slave must not drive data
    startCond();
    sendByte({4'b1010, 3'b100, 1'b1}, 1'b0, "R3");
    readByte(8'hFF, 1'b0, "R3");
    stopCond();

    // R2: wrong type code rejected, write not performed
    startCond();
    sendByte({4'b1011, STRAP, 1'b0}, 1'b0, "R2");
    sendByte(8'h00, 1'b0, "R2");
    sendByte(8'h40, 1'b0, "R2");
    sendByte(8'h99, 1'b0, "R2");
    stopCond();
    setAddr(16'h0040);
    readRun(1, "R2");

    // R7: after NACK the slave stays released on further clocks
    curReq = "R7";
    for (int k = 0; k < 9; k++) begin
      slot(1'b1, 1'b0, s);
      check(s === 1'b1, "R7", "line after nack", int'(s), 1);
    end
    stopCond();

    // R10: STOP in the middle of the address leaves pointer at 0x41
    startCond();
    sendByte(ctl(STRAP, 1'b0), 1'b1, "R10");
    sendByte(8'h07, 1'b1, "R10");
    stopCond();
    check(sdaOe === 1'b0, "R10", "released after stop", int'(sdaOe), 0);
    readRun(1, "R10");
    stopCond();

    // R4: ack on the data byte of a single write, checked at the read side too
    writeSeq(16'h0300, 1, 32'h3C00_0000);
    setAddr(16'h0300);
    readRun(1, "R4");
    stopCond();

    waitQ(2);
    finishRun();
  end

endmodule